// File: doc/BRIEF.md
# Key-Protected Control Register Bank

This block is a bank of 32-bit control words on a simple synchronous register bus. The bus addresses 32-bit words inside a 4 KB window, so the address is a 10-bit word index. A protection latch guards the bank. After reset the latch is set, and ordinary writes are then thrown away. The latch can only be cleared or set again by writing one of two 16-bit magic keys to two dedicated write-only words. The control word at index 0 and the two key words ignore the latch.

Every word index belongs to one access class: read-write, read-only, write-only or unmapped. An access that its class forbids produces an error pulse. Some words come out of reset with fixed non-zero values. These are the PLL control words, a pin-routing array and a few status words. When the bank is open, setting bit 0 of the peripheral reset word sends a one-cycle soft-reset request to an external reset controller. The block does not reset itself in response. What the stored words mean to clocks or pins is left to the logic that consumes them.

Top module: `ctl_keybank`

## Requirements
- R1: After reset the lock status word (index 0x003) reads 1, so the bank starts locked, and the control word (index 0x000) reads 0.
- R2: A write to index 0x001 whose low 16 bits equal 0x767B sets the lock. Any other value leaves the lock unchanged. Such a write never raises an error.
- R3: A write to index 0x002 whose low 16 bits equal 0xDF0D clears the lock, whatever the upper 16 bits hold. Any other value is ignored.
- R4: While locked, a write to a read-write word is discarded without error and the stored value reads back unchanged. While unlocked, the written value is stored and reads back.
- R5: A write to index 0x000 takes effect whether or not the bank is locked. Only bit 0 is stored, and bits 31:1 read as 0.
- R6: Reset values: PLL control words 0x040–0x042 read 0x0001A008, PLL status 0x043 reads 0x0000003F, boot mode 0x044 reads 0x00000001, reset reason 0x081 reads 0x00000040, and the peripheral reset word 0x080 reads 0.
- R7: The pin-routing array has 54 read-write words at indices 0x1C0–0x1F5. Entry i resets to 0x00000601 for i from 2 to 8 and to 0x00001601 otherwise.
- R8: The read-only words (0x003, 0x043, 0x044, 0x045) accept reads without error. A write to any of them raises the error and changes nothing.
- R9: A read of a write-only word (0x001, 0x002, and the trigger words 0x046 and 0x047) raises the error and returns 0. Any access to an unmapped index raises the error, and a read of one returns 0.
- R10: Read data and error are registered. Both are valid in the cycle after the access is sampled. The error is high for exactly one cycle per illegal access and low after legal accesses and idle cycles. Read data is 0 after a write or an idle cycle.
- R11: A write to index 0x080 with bit 0 set, while unlocked, raises soft_rst_req for exactly the following cycle. A locked write, or a write with bit 0 clear, gives no pulse.
- R12: The identification word (index 0x045) reads the ID_WORD parameter, which defaults to 0x0A5C0001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | An access is presented this cycle |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 10 | Word index (byte offset divided by 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_err | output | 1 | One-cycle illegal-access pulse |
| soft_rst_req | output | 1 | One-cycle soft-reset request |

## Verification
Directed sequences cover the lock handshake. Near-miss keys and keys with garbage in the upper half show that only the low 16 bits of an exact key matter. Writing the same word before and after unlocking shows that a discarded write differs from a stored one. Constrained random traffic then mixes reads and writes over every access class with a high rate of key values, so lock state, class errors and soft-reset pulses interleave. A reference model predicts read data, error and request for every access, which separates a wrongly decoded class from a wrongly gated write.

// File: rtl/ctl_keybank_pkg.sv
package ctl_keybank_pkg;

  localparam int WORD_W = 10;

  typedef enum logic [1:0] {ACC_RW, ACC_RO, ACC_WO, ACC_NONE} acc_e;

  typedef enum logic [3:0] {
    K_CTL, K_LOCK, K_UNLOCK, K_LSTAT, K_PLL, K_PSTAT, K_BOOT,
    K_IDW, K_TRIG, K_RSTC, K_WHY, K_MUX, K_NONE
  } kind_e;

  localparam int unsigned W_CTL    = 32'h000;
  localparam int unsigned W_LOCK   = 32'h001;
  localparam int unsigned W_UNLOCK = 32'h002;
  localparam int unsigned W_LSTAT  = 32'h003;
  localparam int unsigned W_PLL    = 32'h040;
  localparam int unsigned W_RSTC   = 32'h080;
  localparam int unsigned W_WHY    = 32'h081;
  localparam int unsigned W_MUX    = 32'h1C0;

  localparam logic [15:0] LOCK_KEY   = 16'h767B;
  localparam logic [15:0] UNLOCK_KEY = 16'hDF0D;

  localparam logic [31:0] PLL_RST_VAL  = 32'h0001_A008;
  localparam logic [31:0] WHY_RST_VAL  = 32'h0000_0040;
  localparam logic [31:0] MUX_RST_VAL  = 32'h0000_1601;
  localparam logic [31:0] MUX_ALT_VAL  = 32'h0000_0601;
  localparam int          MUX_ALT_LO   = 2;
  localparam int          MUX_ALT_HI   = 8;

  // Reset value of one storage slot: PLL words, reset control, reset
  // reason, then the pin-routing array.
  function automatic logic [31:0] slot_init(input int s, input int pll_n);
    int idx;
    if (s < pll_n)           return PLL_RST_VAL;
    else if (s == pll_n)     return 32'h0;
    else if (s == pll_n + 1) return WHY_RST_VAL;
    idx = s - pll_n - 2;
    if (idx >= MUX_ALT_LO && idx <= MUX_ALT_HI) return MUX_ALT_VAL;
    return MUX_RST_VAL;
  endfunction

endpackage

// File: rtl/ctl_keybank_decode.sv
module ctl_keybank_decode
  import ctl_keybank_pkg::*;
#(
  parameter int PLL_N  = 3,
  parameter int MUX_N  = 54,
  parameter int SLOT_W = 6
) (
  input  logic [WORD_W-1:0] word,
  output acc_e              acc,
  output kind_e             kind,
  output logic [SLOT_W-1:0] slot
);

  localparam int unsigned W_PSTAT = W_PLL + PLL_N;
  localparam int unsigned W_BOOT  = W_PSTAT + 1;
  localparam int unsigned W_IDW   = W_PSTAT + 2;
  localparam int unsigned W_TRIG0 = W_PSTAT + 3;
  localparam int unsigned W_TRIG1 = W_PSTAT + 4;
  localparam int unsigned S_RSTC  = PLL_N;
  localparam int unsigned S_WHY   = PLL_N + 1;
  localparam int unsigned S_MUX0  = PLL_N + 2;

  logic [31:0] wi;
  assign wi = 32'(word);

  always_comb begin
    acc  = ACC_NONE;
    kind = K_NONE;
    slot = '0;
    if (wi == W_CTL) begin
      acc = ACC_RW; kind = K_CTL;
    end else if (wi == W_LOCK) begin
      acc = ACC_WO; kind = K_LOCK;
    end else if (wi == W_UNLOCK) begin
      acc = ACC_WO; kind = K_UNLOCK;
    end else if (wi == W_LSTAT) begin
      acc = ACC_RO; kind = K_LSTAT;
    end else if (wi >= W_PLL && wi < W_PSTAT) begin
      acc = ACC_RW; kind = K_PLL;
      slot = SLOT_W'(wi - W_PLL);
    end else if (wi == W_PSTAT) begin
      acc = ACC_RO; kind = K_PSTAT;
    end else if (wi == W_BOOT) begin
      acc = ACC_RO; kind = K_BOOT;
    end else if (wi == W_IDW) begin
      acc = ACC_RO; kind = K_IDW;
    end else if (wi == W_TRIG0 || wi == W_TRIG1) begin
      acc = ACC_WO; kind = K_TRIG;
    end else if (wi == W_RSTC) begin
      acc = ACC_RW; kind = K_RSTC;
      slot = SLOT_W'(S_RSTC);
    end else if (wi == W_WHY) begin
      acc = ACC_RW; kind = K_WHY;
      slot = SLOT_W'(S_WHY);
    end else if (wi >= W_MUX && wi < W_MUX + MUX_N) begin
      acc = ACC_RW; kind = K_MUX;
      slot = SLOT_W'(wi - W_MUX + S_MUX0);
    end
  end

endmodule

// File: rtl/ctl_keybank_lock.sv
module ctl_keybank_lock
  import ctl_keybank_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_lock,
  input  logic        wr_unlock,
  input  logic [15:0] key,
  output logic        locked
);

  logic lock_d;

  always_comb begin
    lock_d = locked;
    if (wr_lock && key == LOCK_KEY)
      lock_d = 1'b1;
    else if (wr_unlock && key == UNLOCK_KEY)
      lock_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) locked <= 1'b1;
    else        locked <= lock_d;
  end

endmodule

// File: rtl/ctl_keybank_store.sv
module ctl_keybank_store
  import ctl_keybank_pkg::*;
#(
  parameter int PLL_N  = 3,
  parameter int NSLOT  = 59,
  parameter int SLOT_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [SLOT_W-1:0] wslot,
  input  logic [31:0]       wdata,
  input  logic [SLOT_W-1:0] rslot,
  output logic [31:0]       rword
);

  logic [31:0] mem_q [NSLOT];
  logic [31:0] mem_d [NSLOT];
  logic [NSLOT-1:0] en;

  for (genvar g = 0; g < NSLOT; g++) begin : g_en
    assign en[g] = we && (32'(wslot) == g);
  end

  always_comb begin
    for (int s = 0; s < NSLOT; s++)
      mem_d[s] = en[s] ? wdata : mem_q[s];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NSLOT; s++) mem_q[s] <= slot_init(s, PLL_N);
    end else begin
      for (int s = 0; s < NSLOT; s++) mem_q[s] <= mem_d[s];
    end
  end

  assign rword = (32'(rslot) < NSLOT) ? mem_q[rslot] : 32'h0;

endmodule

// File: rtl/ctl_keybank.sv
module ctl_keybank
  import ctl_keybank_pkg::*;
#(
  parameter int          PLL_N     = 3,
  parameter int          MUX_N     = 54,
  parameter logic [31:0] PSTAT_VAL = 32'h0000_003F,
  parameter logic [31:0] BOOT_VAL  = 32'h0000_0001,
  parameter logic [31:0] ID_WORD   = 32'h0A5C_0001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [WORD_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_err,
  output logic              soft_rst_req
);

  localparam int NSLOT  = PLL_N + 2 + MUX_N;
  localparam int SLOT_W = $clog2(NSLOT);

  acc_e              acc;
  kind_e             kind;
  logic [SLOT_W-1:0] slot;
  logic              locked;
  logic [31:0]       rword;

  logic wr, rd, open_bank, st_we, ctl_we, ill;
  logic ctl_q, ctl_d;
  logic [31:0] rdata_d;
  logic srst_d;

  ctl_keybank_decode #(.PLL_N(PLL_N), .MUX_N(MUX_N), .SLOT_W(SLOT_W)) u_dec (
    .word (bus_addr),
    .acc  (acc),
    .kind (kind),
    .slot (slot)
  );

  assign wr        = bus_sel && bus_we;
  assign rd        = bus_sel && !bus_we;
  assign open_bank = !locked;

  ctl_keybank_lock u_lock (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_lock   (wr && kind == K_LOCK),
    .wr_unlock (wr && kind == K_UNLOCK),
    .key       (bus_wdata[15:0]),
    .locked    (locked)
  );

  assign st_we = wr && open_bank &&
                 (kind == K_PLL || kind == K_RSTC || kind == K_WHY || kind == K_MUX);

  ctl_keybank_store #(.PLL_N(PLL_N), .NSLOT(NSLOT), .SLOT_W(SLOT_W)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (st_we),
    .wslot (slot),
    .wdata (bus_wdata),
    .rslot (slot),
    .rword (rword)
  );

  // Control word at index 0 bypasses the lock.
  assign ctl_we = wr && kind == K_CTL;
  assign ctl_d  = ctl_we ? bus_wdata[0] : ctl_q;

  assign ill = (wr && (acc == ACC_RO || acc == ACC_NONE)) ||
               (rd && (acc == ACC_WO || acc == ACC_NONE));

  assign srst_d = wr && open_bank && kind == K_RSTC && bus_wdata[0];

  always_comb begin
    rdata_d = 32'h0;
    if (rd) begin
      case (kind)
        K_CTL:   rdata_d = {31'b0, ctl_q};
        K_LSTAT: rdata_d = {31'b0, locked};
        K_PLL,
        K_RSTC,
        K_WHY,
        K_MUX:   rdata_d = rword;
        K_PSTAT: rdata_d = PSTAT_VAL;
        K_BOOT:  rdata_d = BOOT_VAL;
        K_IDW:   rdata_d = ID_WORD;
        default: rdata_d = 32'h0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q        <= 1'b0;
      bus_rdata    <= 32'h0;
      bus_err      <= 1'b0;
      soft_rst_req <= 1'b0;
    end else begin
      ctl_q        <= ctl_d;
      bus_rdata    <= rdata_d;
      bus_err      <= ill;
      soft_rst_req <= srst_d;
    end
  end

endmodule

// File: rtl/ctl_keybank_chk.sv
module ctl_keybank_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_sel,
  input logic        bus_we,
  input logic [9:0]  bus_addr,
  input logic [31:0] bus_wdata,
  input logic [31:0] bus_rdata,
  input logic        bus_err,
  input logic        soft_rst_req,
  input logic        locked
);

  logic seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;
  end

  AST_START_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !seen |-> locked); // R1

  AST_LOCK_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n || !seen)
    $rose(locked) |-> $past(bus_sel && bus_we && bus_addr == 10'h001 &&
                            bus_wdata[15:0] == 16'h767B)); // R2

  AST_UNLOCK_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n || !seen)
    $fell(locked) |-> $past(bus_sel && bus_we && bus_addr == 10'h002 &&
                            bus_wdata[15:0] == 16'hDF0D)); // R3

  AST_CTL_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n || !seen)
    $past(bus_sel && !bus_we && bus_addr == 10'h000) |-> bus_rdata[31:1] == 31'h0); // R5

  AST_ERR_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n || !seen)
    bus_err |-> $past(bus_sel)); // R10

  AST_WRITE_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n || !seen)
    $past(bus_sel && bus_we) |-> bus_rdata == 32'h0); // R10

  AST_SRST_SOURCE: assert property (@(posedge clk) disable iff (!rst_n || !seen)
    soft_rst_req |-> $past(bus_sel && bus_we && bus_addr == 10'h080 &&
                           bus_wdata[0] && !locked)); // R11

endmodule

bind ctl_keybank ctl_keybank_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_sel      (bus_sel),
  .bus_we       (bus_we),
  .bus_addr     (bus_addr),
  .bus_wdata    (bus_wdata),
  .bus_rdata    (bus_rdata),
  .bus_err      (bus_err),
  .soft_rst_req (soft_rst_req),
  .locked       (locked)
);

// File: tb/ctl_keybank_bench.sv
module ctl_keybank_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [9:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_err;
  logic        soft_rst_req;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ctl_keybank u_ctl_keybank (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_sel      (bus_sel),
    .bus_we       (bus_we),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .bus_err      (bus_err),
    .soft_rst_req (soft_rst_req)
  );

  // Reference model state
  bit          m_lock;
  bit          m_ctl;
  logic [31:0] m_pll [3];
  logic [31:0] m_rstc, m_why;
  logic [31:0] m_mux [54];

  // 0 read-write, 1 read-only, 2 write-only, 3 unmapped
  function automatic int cls(input int w);
    if (w == 0) return 0;
    if (w == 1 || w == 2) return 2;
    if (w == 3) return 1;
    if (w >= 64 && w <= 66) return 0;
    if (w >= 67 && w <= 69) return 1;
    if (w == 70 || w == 71) return 2;
    if (w == 128 || w == 129) return 0;
    if (w >= 448 && w < 448 + 54) return 0;
    return 3;
  endfunction

  function automatic logic [31:0] peek(input int w);
    if (w == 0) return {31'b0, m_ctl};
    if (w == 3) return {31'b0, m_lock};
    if (w >= 64 && w <= 66) return m_pll[w-64];
    if (w == 67) return 32'h3F;
    if (w == 68) return 32'h1;
    if (w == 69) return 32'h0A5C_0001;
    if (w == 128) return m_rstc;
    if (w == 129) return m_why;
    if (w >= 448 && w < 448 + 54) return m_mux[w-448];
    return 32'h0;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_lock = 1'b1; m_ctl = 1'b0;
    for (int i = 0; i < 3; i++) m_pll[i] = 32'h0001_A008;
    m_rstc = 32'h0; m_why = 32'h40;
    for (int i = 0; i < 54; i++)
      m_mux[i] = (i >= 2 && i <= 8) ? 32'h601 : 32'h1601;
  endtask

  task automatic xfer(input bit we, input int w, input logic [31:0] d, input string req);
    int c;
    bit e_err, e_srst;
    logic [31:0] e_rd;
    c      = cls(w);
    e_err  = we ? (c == 1 || c == 3) : (c == 2 || c == 3);
    e_rd   = we ? 32'h0 : peek(w);
    e_srst = we && !m_lock && w == 128 && d[0];
    @(negedge clk);
    bus_sel = 1'b1; bus_we = we; bus_addr = 10'(w); bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
    check(bus_err == e_err, req, "err", {31'b0, bus_err}, {31'b0, e_err});
    check(bus_rdata == e_rd, req, "rdata", bus_rdata, e_rd);
    check(soft_rst_req == e_srst, req, "soft_rst_req", {31'b0, soft_rst_req}, {31'b0, e_srst});
    if (we) begin
      if (w == 1 && d[15:0] == 16'h767B) m_lock = 1'b1;
      else if (w == 2 && d[15:0] == 16'hDF0D) m_lock = 1'b0;
      else if (w == 0) m_ctl = d[0];
      else if (!m_lock && c == 0) begin
        if (w >= 64 && w <= 66) m_pll[w-64] = d;
        else if (w == 128) m_rstc = d;
        else if (w == 129) m_why = d;
        else if (w >= 448) m_mux[w-448] = d;
      end
    end
  endtask

  task automatic idle_check(input string req);
    @(negedge clk);
    check(bus_err == 1'b0, req, "idle err", {31'b0, bus_err}, 32'h0);
    check(soft_rst_req == 1'b0, req, "idle soft_rst_req", {31'b0, soft_rst_req}, 32'h0);
    check(bus_rdata == 32'h0, req, "idle rdata", bus_rdata, 32'h0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int pick, w;
    bit we;
    logic [31:0] d;
    void'($urandom(32'd90125));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    check(bus_err == 1'b0 && soft_rst_req == 1'b0, "R1", "outputs after reset",
          {30'b0, bus_err, soft_rst_req}, 32'h0);
    xfer(0, 3, 0, "R1");
    xfer(0, 0, 0, "R1");
    // R6, R12: reset values and identification
    for (int i = 64; i <= 69; i++) xfer(0, i, 0, "R6");
    xfer(0, 128, 0, "R6");
    xfer(0, 129, 0, "R6");
    xfer(0, 69, 0, "R12");
    // R7: pin-routing array reset values
    for (int i = 0; i < 54; i++) xfer(0, 448 + i, 0, "R7");
    // R4: locked writes discarded
    xfer(1, 64, 32'hDEAD_BEEF, "R4");
    xfer(0, 64, 0, "R4");
    xfer(1, 450, 32'h1234, "R4");
    xfer(0, 450, 0, "R4");
    // R3: near-miss keys then a key with garbage above
    xfer(1, 2, 32'h0000_DF0E, "R3");
    xfer(0, 3, 0, "R3");
    xfer(1, 1, 32'h0000_DF0D, "R3");
    xfer(0, 3, 0, "R3");
    xfer(1, 2, 32'hABCD_DF0D, "R3");
    xfer(0, 3, 0, "R3");
    // R4, R7: unlocked writes stored
    xfer(1, 64, 32'h1234_5678, "R4");
    xfer(0, 64, 0, "R4");
    xfer(1, 453, 32'hCAFE_0005, "R7");
    xfer(0, 453, 0, "R7");
    // R2: wrong lock key, then the real one
    xfer(1, 1, 32'h0000_767C, "R2");
    xfer(0, 3, 0, "R2");
    xfer(1, 1, 32'hFFFF_767B, "R2");
    xfer(0, 3, 0, "R2");
    xfer(1, 65, 32'h5555_AAAA, "R2");
    xfer(0, 65, 0, "R2");
    // R5: control word while locked
    xfer(1, 0, 32'hFFFF_FFFF, "R5");
    xfer(0, 0, 0, "R5");
    xfer(1, 0, 32'hFFFF_FFFE, "R5");
    xfer(0, 0, 0, "R5");
    // R8: read-only words reject writes
    xfer(1, 3, 32'h0, "R8");
    xfer(0, 3, 0, "R8");
    xfer(1, 67, 32'h0, "R8");
    xfer(0, 67, 0, "R8");
    xfer(1, 68, 32'h7, "R8");
    xfer(1, 69, 32'h7, "R8");
    xfer(0, 69, 0, "R8");
    // R9: write-only reads and unmapped accesses
    xfer(0, 1, 0, "R9");
    xfer(0, 2, 0, "R9");
    xfer(0, 70, 0, "R9");
    xfer(0, 71, 0, "R9");
    xfer(0, 1023, 0, "R9");
    xfer(1, 1023, 32'h1, "R9");
    xfer(0, 4, 0, "R9");
    xfer(0, 448 + 54, 0, "R9");
    // R10: error pulse lasts one cycle
    idle_check("R10");
    // R11: soft-reset request
    xfer(1, 128, 32'h1, "R11");
    xfer(1, 2, 32'h0000_DF0D, "R11");
    xfer(1, 128, 32'h1, "R11");
    idle_check("R11");
    xfer(1, 128, 32'h2, "R11");
    xfer(0, 128, 0, "R11");
    xfer(1, 70, 32'h1, "R11");

    // Random mix checked against the model (R2 R3 R4 R8 R9 R11)
    for (int n = 0; n < 600; n++) begin
      pick = $urandom_range(0, 15);
      case (pick)
        0: w = 0;  1: w = 1;  2: w = 2;  3: w = 3;
        4, 5, 6: w = 64 + $urandom_range(0, 2);
        7: w = 67; 8: w = 68; 9: w = 69;
        10: w = 70 + $urandom_range(0, 1);
        11: w = 128; 12: w = 129;
        13, 14: w = 448 + $urandom_range(0, 53);
        default: w = $urandom_range(0, 1023);
      endcase
      we = $urandom_range(0, 1) == 1;
      d  = $urandom;
      if (w == 1 && $urandom_range(0, 1) == 1) d[15:0] = 16'h767B;
      if (w == 2 && $urandom_range(0, 1) == 1) d[15:0] = 16'hDF0D;
      xfer(we, w, d, "R4 random");
    end
    idle_check("R10");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule